// File: doc/BRIEF.md
# Load Response Rate Throttler

This block sits on the response path from a data cache into a load/store queue. Every clock cycle it may be offered several responses at once, one on each lane. Each response carries a line-aligned address and a byte count. In the same cycle the block decides which of them the queue takes. Two per-cycle limits apply: a byte budget and a cap on the number of distinct cache lines. Both limits start fresh on every clock edge.

When a response is refused, the cache must offer it again. The block asks for that by raising a single-cycle retry pulse on the following cycle. A response larger than the free byte budget is not simply stalled. The budget that is still free is used up in the refusing cycle, and the rest of the byte count is carried forward as a pending amount. That pending amount is paid off at up to one full budget per cycle on later offers. The offer that finds the pending amount fully covered is accepted.

Three running counters report the accepted responses, the accepted bytes and the retry pulses issued. An enable input turns the limits off: with it low, every offered response passes and any pending amount is dropped.

Top module: `load_resp_throttle`

## Requirements
- R1: After reset the retry pulse is low and all three counters are zero. A lane with its valid low is never accepted.
- R2: With `thr_en` low, every valid lane is accepted, no retry follows, and the pending carry is cleared to zero.
- R3: Lanes are judged in rising index order, and lanes whose valid is low are skipped. Once a valid lane is refused in a cycle, every higher valid lane is refused in that cycle too.
- R4: With no pending carry, a response is refused when its size exceeds `BUF_BYTES` minus the bytes taken by lower lanes in the same cycle. Otherwise it is accepted and its size is added to the bytes taken. The bytes taken restart at zero every cycle.
- R5: Each cycle, the line record starts at address 0 and the line count at zero. A response counts as a new line when its line address differs from the recorded one. If a new line would push the count above `MAX_LINES`, the response is refused. When a new-line response is accepted, the count increments and the record takes its address.
- R6: When a refusal with no pending carry is caused only by the byte budget (the line cap alone would not refuse it), the pending carry becomes the size minus the free budget, and the budget for the rest of that cycle is exhausted.
- R7: While the carry is nonzero, the first valid lane of a cycle is judged on the carry alone, not on its own size. If the carry exceeds `BUF_BYTES`, the lane is refused and the carry drops by `BUF_BYTES`. Otherwise the lane is accepted, the carry goes to zero, and the old carry value counts as the bytes taken.
- R8: `retry_pulse` is high for exactly the one cycle that follows a cycle in which `thr_en` was high and at least one valid lane was refused.
- R9: `cnt_resp` grows by the number of accepted lanes and `cnt_bytes` by the sum of their sizes. `cnt_retry` grows by one per retry pulse. All three update on the clock edge that closes the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_en | input | 1 | High enables the limits |
| rsp_valid | input | LANES | Per-lane response offered |
| rsp_line | input | LANES*LINE_W | Per-lane line address, lane 0 in the low bits |
| rsp_size | input | LANES*SIZE_W | Per-lane byte count, lane 0 in the low bits |
| rsp_accept | output | LANES | Per-lane acceptance, same cycle |
| retry_pulse | output | 1 | One-cycle request to re-offer refused responses |
| cnt_resp | output | CNT_W | Accepted responses |
| cnt_bytes | output | CNT_W | Accepted response bytes |
| cnt_retry | output | CNT_W | Retry pulses issued |

## Verification
The only hidden state is the pending carry, and a wrong carry shows up at the ports in the very next cycle that has a valid offer. That offer is then accepted or refused against the carry instead of its own size, and the same decision moves the retry pulse one cycle later. A broken per-cycle reset of the byte or line tallies shows up in the same cycle as the wrong accept pattern on the higher lane. Counter errors appear at the next clock edge. For that reason the bench compares accepts, the retry pulse and all counters on every cycle of a long sweep.

// File: rtl/load_resp_throttle.sv
module load_resp_throttle #(
  parameter int LANES     = 2,
  parameter int BUF_BYTES = 64,
  parameter int MAX_LINES = 2,
  parameter int SIZE_W    = 8,
  parameter int LINE_W    = 26,
  parameter int CNT_W     = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      thr_en,
  input  logic [LANES-1:0]          rsp_valid,
  input  logic [LANES*LINE_W-1:0]   rsp_line,
  input  logic [LANES*SIZE_W-1:0]   rsp_size,
  output logic [LANES-1:0]          rsp_accept,
  output logic                      retry_pulse,
  output logic [CNT_W-1:0]          cnt_resp,
  output logic [CNT_W-1:0]          cnt_bytes,
  output logic [CNT_W-1:0]          cnt_retry
);

  localparam int UW = $clog2(BUF_BYTES + 1);
  localparam int AW = ((SIZE_W > UW) ? SIZE_W : UW) + 1;
  localparam int NW = $clog2(LANES + MAX_LINES + 1) + 1;
  localparam logic [AW-1:0] BUF = AW'(BUF_BYTES);
  localparam logic [NW-1:0] MAXL = NW'(MAX_LINES);

  logic [AW-1:0]     pend_q, pend_d;
  logic [AW-1:0]     used, carry, sz, free;
  logic [NW-1:0]     lines;
  logic [LINE_W-1:0] last, ln;
  logic              blk, nl, over_l, over_b;
  logic [LANES-1:0]  acc;
  logic [CNT_W-1:0]  add_r, add_b;

  always_comb begin
    used  = '0;
    lines = '0;
    last  = '0;
    carry = pend_q;
    blk   = 1'b0;
    acc   = '0;
    add_r = '0;
    add_b = '0;
    sz = '0; free = '0; ln = '0; nl = 1'b0; over_l = 1'b0; over_b = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      ln     = rsp_line[i*LINE_W +: LINE_W];
      sz     = AW'(rsp_size[i*SIZE_W +: SIZE_W]);
      nl     = (ln != last);
      free   = BUF - used;
      over_l = (lines + NW'(nl)) > MAXL;
      over_b = sz > free;
      if (rsp_valid[i] && !blk) begin
        if (!thr_en) begin
          acc[i] = 1'b1;
        end else if (carry == '0) begin
          if (over_l || over_b) begin
            blk = 1'b1;
            if (!over_l) begin
              carry = sz - free;
              used  = BUF;
            end
          end else begin
            acc[i] = 1'b1;
            used   = used + sz;
          end
        end else if (carry > BUF) begin
          blk   = 1'b1;
          carry = carry - BUF;
          used  = BUF;
        end else begin
          acc[i] = 1'b1;
          used   = carry;
          carry  = '0;
        end
        if (acc[i]) begin
          if (nl) begin
            lines = lines + 1'b1;
            last  = ln;
          end
          add_r = add_r + 1'b1;
          add_b = add_b + CNT_W'(rsp_size[i*SIZE_W +: SIZE_W]);
        end
      end
    end
    pend_d = thr_en ? carry : '0;
  end

  assign rsp_accept = acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= '0;
      retry_pulse <= 1'b0;
      cnt_resp    <= '0;
      cnt_bytes   <= '0;
      cnt_retry   <= '0;
    end else begin
      pend_q      <= pend_d;
      retry_pulse <= thr_en && blk;
      cnt_resp    <= cnt_resp + add_r;
      cnt_bytes   <= cnt_bytes + add_b;
      cnt_retry   <= cnt_retry + CNT_W'(retry_pulse);
    end
  end

  AST_BUDGET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    used <= BUF); // R4

  AST_ACCEPT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_accept & ~rsp_valid) == '0); // R1

  AST_OFF_PASSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_en |-> rsp_accept == rsp_valid); // R2

  AST_RETRY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse |-> $past(thr_en && (rsp_valid != rsp_accept))); // R8

  AST_RETRY_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
    retry_pulse |=> cnt_retry == $past(cnt_retry) + 1'b1); // R9

  for (genvar g = 1; g < LANES; g++) begin : g_order
    AST_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_en && rsp_valid[g-1] && !rsp_accept[g-1]) |-> !rsp_accept[g]); // R3
  end

endmodule

// File: tb/sim_load_resp_throttle.sv
`timescale 1ns/1ps
module sim_load_resp_throttle;
  localparam int BUFB = 8;
  localparam int ML   = 1;
  localparam int CW   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [1:0] vld = '0;
  logic [3:0] lines = '0;
  logic [9:0] sizes = '0;
  logic [1:0] acc;
  logic retry_pulse;
  logic [CW-1:0] cnt_resp, cnt_bytes, cnt_retry;

  int total = 0, bad = 0;
  int m_pend = 0, m_resp = 0, m_bytes = 0, m_retry = 0;
  bit m_rflag = 0;

  always #2 clk = ~clk;

  load_resp_throttle #(.LANES(2), .BUF_BYTES(BUFB), .MAX_LINES(ML),
    .SIZE_W(5), .LINE_W(2), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .thr_en(en), .rsp_valid(vld),
    .rsp_line(lines), .rsp_size(sizes), .rsp_accept(acc),
    .retry_pulse(retry_pulse), .cnt_resp(cnt_resp), .cnt_bytes(cnt_bytes),
    .cnt_retry(cnt_retry));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit e, input bit [1:0] v, input int l0, input int l1,
                      input int s0, input int s1, input string tag);
    int ls[2], ss[2];
    int taken, cnt, rec, p;
    bit stop, isnew;
    bit [1:0] ea;
    string t;
    ls[0] = l0; ls[1] = l1; ss[0] = s0; ss[1] = s1;
    @(negedge clk);
    en = e; vld = v;
    lines = {2'(l1), 2'(l0)};
    sizes = {5'(s1), 5'(s0)};
    #1;
    taken = 0; cnt = 0; rec = 0; p = m_pend; stop = 0; ea = '0;
    for (int k = 0; k < 2; k++) begin
      if (!v[k] || stop) continue;
      isnew = (ls[k] != rec);
      if (!e) ea[k] = 1;
      else if (p > 0) begin
        if (p > BUFB) begin stop = 1; p -= BUFB; taken = BUFB; end
        else begin ea[k] = 1; taken = p; p = 0; end
      end else if (cnt + isnew > ML) stop = 1;
      else if (ss[k] > BUFB - taken) begin
        stop = 1; p = ss[k] - (BUFB - taken); taken = BUFB;
      end else begin ea[k] = 1; taken += ss[k]; end
      if (ea[k]) begin
        if (isnew) begin cnt++; rec = ls[k]; end
        m_resp++; m_bytes += ss[k];
      end
    end
    t = (tag != "") ? tag : (!e ? "R2" : (m_pend != 0 ? "R7" : "R4"));
    chk(t, acc, ea);
    chk("R8", retry_pulse, m_rflag);
    chk("R9", cnt_retry, m_retry);
    if (m_rflag) m_retry++;
    m_rflag = e && ((v & ~ea) != 0);
    m_pend = e ? p : 0;
    @(posedge clk); #1;
    chk("R9", cnt_resp, m_resp);
    chk("R9", cnt_bytes, m_bytes);
  endtask

  initial begin
    #1200000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", retry_pulse, 0);
    chk("R1", cnt_resp, 0);
    chk("R1", cnt_bytes, 0);
    chk("R1", cnt_retry, 0);
    chk("R1", acc, 0);
    @(negedge clk); rst_n = 1'b1;
    step(1, 2'b00, 0, 0, 3, 3, "R1");
    step(1, 2'b11, 1, 2, 1, 1, "R5");
    step(1, 2'b11, 0, 1, 2, 2, "R5");
    step(1, 2'b11, 1, 1, 5, 3, "R4");
    step(1, 2'b11, 1, 1, 5, 4, "R6");
    step(1, 2'b01, 1, 1, 4, 0, "R7");
    step(1, 2'b01, 2, 0, 20, 0, "R6");
    step(1, 2'b01, 2, 0, 20, 0, "R7");
    step(1, 2'b11, 2, 2, 20, 4, "R7");
    step(1, 2'b10, 0, 3, 0, 9, "R3");
    step(1, 2'b11, 1, 1, 9, 1, "R3");
    step(1, 2'b01, 1, 0, 31, 0, "R6");
    step(0, 2'b11, 1, 2, 30, 30, "R2");
    step(1, 2'b01, 3, 0, 2, 0, "R2");
    for (int n = 0; n < 16384; n++) begin
      step((n % 11) != 5, 2'(n), (n >> 2) & 3, (n >> 4) & 3,
           (n >> 6) & 15, (n >> 10) & 15, "");
    end
    step(1, 2'b00, 0, 0, 0, 0, "R8");
    step(1, 2'b00, 0, 0, 0, 0, "R9");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule